// File: doc/BRIEF.md
# Advertised Power Derating Selector

This block works out the power rating that a USB Power Delivery source port offers to an attached sink. A configured maximum power is first scaled by a fraction that a 2-bit pin strap selects. The result is then reduced when the battery supply is low or when the board thermistor reports a warning temperature. The final figure is held in a register. Each time it changes, a one-cycle request tells the protocol layer to send new capabilities.

All power values use 0.5 W units, so 120 means 60 W. The pin strap, the battery-low flag and the thermal-warning flag are asynchronous. Each passes through a two-flop synchroniser. The pin strap is also debounced. The battery-low flag must hold for a qualification window of about 2 ms before it is acted on. Scaling uses integer multiply-and-shift, and every step truncates.

Top module: `pd_derate_sel`

## Requirements
- R1: With no derating condition active, the advertised value S is (cfg_max_pwr * (code + 1)) >> 2, truncated. The select code is the value of sel_pins, with sel_pins[1] as the MSB: 3 gives 100%, 2 gives 75%, 1 gives 50% and 0 gives 25%.
- R2: With exactly one of battery-low or thermal-warning qualified, the advertised value is (S * 3) >> 2, truncated.
- R3: With both conditions qualified, the advertised value is S >> 2.
- R4: The battery-low flag takes effect only after it has been high continuously for BAT_HOLD cycles after synchronisation. Shorter pulses change neither adv_pwr nor reneg_req.
- R5: When the battery-low or thermal-warning input falls, the undated value S is advertised again within five clock cycles.
- R6: A new select code is adopted only after it has been stable for SEL_DEB cycles after synchronisation. Shorter glitches have no effect on adv_pwr.
- R7: reneg_req is high for exactly one cycle each time adv_pwr takes a new value. It stays low when a recomputation gives the value already advertised. adv_pwr never changes without it.
- R8: During reset, adv_pwr is 0 and reneg_req is 0. The debounced select code resets to 3. The first value computed after reset is announced with one reneg_req pulse.
- R9: adv_pwr never exceeds the cfg_max_pwr value applied on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_max_pwr | input | PW (9) | Configured maximum power, 0.5 W units, quasi-static |
| sel_pins | input | 2 | Asynchronous pin-strap fraction select |
| bat_low_in | input | 1 | Asynchronous battery-low flag |
| therm_warn_in | input | 1 | Asynchronous thermistor warning flag |
| adv_pwr | output | PW (9) | Currently advertised power, 0.5 W units |
| reneg_req | output | 1 | One-cycle request to resend capabilities |

## Verification
The bench builds the block with SEL_DEB = 4 and BAT_HOLD = 16 instead of the millisecond-scale defaults. With these values, both qualification windows can be crossed within a few dozen cycles. Glitches just shorter than a window and holds just longer than it both fit into a short directed sequence. The default 9-bit width is kept, so a maximum of 511 exercises the widest intermediate products and the truncation at every step. A maximum of 3 drives the result to 0, where some input changes must produce no renegotiation at all.

// File: rtl/pd_derate_pkg.sv
// Shared types for the advertised power derating selector.
// Assumes power values are unsigned counts of 0.5 W.
package pd_derate_pkg;

    typedef enum logic [1:0] {
        DR_NONE = 2'd0,
        DR_ONE  = 2'd1,
        DR_BOTH = 2'd2
    } derate_e;

    // Classify the active derating conditions.
    function automatic derate_e derate_class(input logic bat_q, input logic th_q);
        if (bat_q && th_q)      return DR_BOTH;
        else if (bat_q || th_q) return DR_ONE;
        else                    return DR_NONE;
    endfunction

endpackage

// File: rtl/pdr_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; multi-bit coherence is left to the debounce that follows.
module pdr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // One flop stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= RV;
                else if (gi == 0) stage_q[gi] <= d_async;
                else stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pdr_sel_filter.sv
// Debounce for the synchronised select code: a new code is adopted once it has
// stayed the same for DEB cycles. Assumes DEB >= 1.
module pdr_sel_filter #(
    parameter int W   = 2,
    parameter int DEB = 64,
    parameter logic [W-1:0] RV = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB - 1);

    logic [W-1:0]  cand_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  out_q;

    // Track the candidate code, count its stable cycles and adopt it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= RV;
            cnt_q  <= '0;
            out_q  <= RV;
        end else if (din != cand_q) begin
            cand_q <= din;
            cnt_q  <= '0;
        end else if (cnt_q == CNT_LAST) begin
            out_q  <= cand_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign dout = out_q;

    // R6
    sel_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (out_q == $past(din)));
endmodule

// File: rtl/pdr_hold_filter.sv
// Qualifies the battery-low flag: the output rises after the input has been high
// for HOLD consecutive cycles and falls on the first cycle the input is low.
// Assumes HOLD >= 1.
module pdr_hold_filter #(
    parameter int HOLD = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;
    logic          q;

    // Count the high run and assert the qualified flag at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !din) begin
            cnt_q <= '0;
            q     <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            q     <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = q;

    // R4
    bat_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(din));

    // R5
    bat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !q);
endmodule

// File: rtl/pdr_scaler.sv
// Combinational power scaling: pin-selected fraction, then condition derating.
// Assumes all products fit in PW+3 bits, which holds for a 2-bit select.
module pdr_scaler
    import pd_derate_pkg::*;
#(
    parameter int PW = 9
) (
    input  logic [PW-1:0] max_pwr,
    input  logic [1:0]    sel_code,
    input  logic          bat_q,
    input  logic          th_q,
    output logic [PW-1:0] pwr
);
    localparam int XW = PW + 3;

    logic [XW-1:0] sel_mult;
    logic [XW-1:0] prod_sel;
    logic [PW-1:0] s_pwr;
    logic [XW-1:0] prod_thr;
    logic [PW-1:0] s_three_q;
    logic [PW-1:0] s_quarter;
    derate_e       cls;

    // Pin-selected share: max * (code + 1) / 4 with truncation.
    always_comb begin
        sel_mult = XW'(sel_code) + XW'(1);
        prod_sel = XW'(max_pwr) * sel_mult;
        s_pwr    = prod_sel[PW+1:2];
    end

    // Derated options: three quarters and one quarter of the selected share.
    always_comb begin
        prod_thr  = XW'(s_pwr) * XW'(3);
        s_three_q = prod_thr[PW+1:2];
        s_quarter = s_pwr >> 2;
    end

    // Pick the option for the active condition set.
    always_comb begin
        cls = derate_class(bat_q, th_q);
        unique case (cls)
            DR_ONE:  pwr = s_three_q;
            DR_BOTH: pwr = s_quarter;
            default: pwr = s_pwr;
        endcase
    end

    // R2 R3
    always_comb begin
        derate_bound_chk: assert (pwr <= s_pwr);
    end
endmodule

// File: rtl/pd_derate_sel.sv
// Advertised power derating selector top. Synchronises and filters the strap and
// condition inputs, computes the power to advertise and pulses a renegotiation
// request on every change. Assumes cfg_max_pwr is quasi-static and needs no synchroniser.
module pd_derate_sel #(
    parameter int PW       = 9,
    parameter int SEL_DEB  = 64,
    parameter int BAT_HOLD = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_max_pwr,
    input  logic [1:0]    sel_pins,
    input  logic          bat_low_in,
    input  logic          therm_warn_in,
    output logic [PW-1:0] adv_pwr,
    output logic          reneg_req
);
    logic [1:0]    sel_sync;
    logic [1:0]    sel_code;
    logic          bat_sync;
    logic          bat_q;
    logic          th_sync;
    logic [PW-1:0] pwr_next;
    logic [PW-1:0] adv_q;
    logic          reneg_q;

    pdr_sync #(.W(2), .STAGES(2), .RV(2'b11)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d_async(sel_pins), .d_sync(sel_sync));

    pdr_sync #(.W(1), .STAGES(2), .RV(1'b0)) u_bat_sync (
        .clk(clk), .rst_n(rst_n), .d_async(bat_low_in), .d_sync(bat_sync));

    pdr_sync #(.W(1), .STAGES(2), .RV(1'b0)) u_th_sync (
        .clk(clk), .rst_n(rst_n), .d_async(therm_warn_in), .d_sync(th_sync));

    pdr_sel_filter #(.W(2), .DEB(SEL_DEB), .RV(2'b11)) u_sel_filt (
        .clk(clk), .rst_n(rst_n), .din(sel_sync), .dout(sel_code));

    pdr_hold_filter #(.HOLD(BAT_HOLD)) u_bat_filt (
        .clk(clk), .rst_n(rst_n), .din(bat_sync), .dout(bat_q));

    pdr_scaler #(.PW(PW)) u_scale (
        .max_pwr(cfg_max_pwr), .sel_code(sel_code),
        .bat_q(bat_q), .th_q(th_sync), .pwr(pwr_next));

    // Register the advertised value and flag each change for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q   <= '0;
            reneg_q <= 1'b0;
        end else if (pwr_next != adv_q) begin
            adv_q   <= pwr_next;
            reneg_q <= 1'b1;
        end else begin
            reneg_q <= 1'b0;
        end
    end

    assign adv_pwr   = adv_q;
    assign reneg_req = reneg_q;

    // R7
    reneg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reneg_q |-> (adv_q != $past(adv_q)));

    // R7
    adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reneg_q |-> $stable(adv_q));

    // R9
    adv_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_q <= $past(cfg_max_pwr));
endmodule

// File: tb/tb_pd_derate_sel.sv
module tb_pd_derate_sel;
    localparam int PW = 9;
    localparam int SEL_DEB = 4;
    localparam int BAT_HOLD = 16;
    localparam int SETTLE = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] cfg_max_pwr = 9'd120;
    logic [1:0]    sel_pins = 2'b11;
    logic          bat_low_in = 1'b0;
    logic          therm_warn_in = 1'b0;
    logic [PW-1:0] adv_pwr;
    logic          reneg_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pd_derate_sel #(.PW(PW), .SEL_DEB(SEL_DEB), .BAT_HOLD(BAT_HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_max_pwr(cfg_max_pwr), .sel_pins(sel_pins),
        .bat_low_in(bat_low_in), .therm_warn_in(therm_warn_in),
        .adv_pwr(adv_pwr), .reneg_req(reneg_req));

    // Vector: {cfg_max_pwr[8:0], sel[1:0], bat, therm}; one input changes per step.
    localparam logic [12:0] VEC [19] = '{
        {9'd120, 2'b11, 1'b0, 1'b0}, {9'd120, 2'b10, 1'b0, 1'b0},
        {9'd120, 2'b01, 1'b0, 1'b0}, {9'd120, 2'b00, 1'b0, 1'b0},
        {9'd120, 2'b00, 1'b0, 1'b1}, {9'd120, 2'b00, 1'b1, 1'b1},
        {9'd120, 2'b10, 1'b1, 1'b1}, {9'd120, 2'b10, 1'b0, 1'b1},
        {9'd120, 2'b10, 1'b0, 1'b0}, {9'd120, 2'b11, 1'b0, 1'b0},
        {9'd120, 2'b11, 1'b1, 1'b0}, {9'd511, 2'b11, 1'b1, 1'b0},
        {9'd511, 2'b10, 1'b1, 1'b0}, {9'd511, 2'b10, 1'b1, 1'b1},
        {9'd3,   2'b10, 1'b1, 1'b1}, {9'd3,   2'b10, 1'b0, 1'b1},
        {9'd3,   2'b00, 1'b0, 1'b1}, {9'd3,   2'b00, 1'b0, 1'b0},
        {9'd3,   2'b00, 1'b1, 1'b0}
    };

    // Expected value from R1 to R3.
    function automatic int expect_pwr(int mx, int code, bit b, bit t);
        int s;
        s = (mx * (code + 1)) / 4;
        if (b && t) return s / 4;
        if (b || t) return (s * 3) / 4;
        return s;
    endfunction

    // Count reneg pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && reneg_req) pulses++;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        cyc(5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int prev;
        int exp;
        cyc(3);
        // R8: reset state
        check("R8 adv in reset", adv_pwr, 0);
        check("R8 reneg in reset", reneg_req, 0);
        rst_n = 1'b1;
        cyc(10);
        check("R8 first value", adv_pwr, 120);
        check("R8 first pulse", pulses, 1);
        prev = 120;

        // Table walk: R1 R2 R3 R7 R9
        for (int k = 0; k < 19; k++) begin
            cfg_max_pwr   = VEC[k][12:4];
            sel_pins      = VEC[k][3:2];
            bat_low_in    = VEC[k][1];
            therm_warn_in = VEC[k][0];
            pulses = 0;
            cyc(SETTLE);
            exp = expect_pwr(int'(VEC[k][12:4]), int'(VEC[k][3:2]), VEC[k][1], VEC[k][0]);
            check("R1/R2/R3 value", adv_pwr, exp);
            check("R7 pulse count", pulses, (exp != prev) ? 1 : 0);
            prev = exp;
        end

        // Return to a known full-power state.
        cfg_max_pwr = 9'd120; sel_pins = 2'b11; bat_low_in = 0; therm_warn_in = 0;
        cyc(SETTLE);
        pulses = 0;

        // R4: short battery-low pulse is ignored
        bat_low_in = 1'b1; cyc(BAT_HOLD - 6); bat_low_in = 1'b0; cyc(30);
        check("R4 glitch value", adv_pwr, 120);
        check("R4 glitch pulses", pulses, 0);

        // R4: a held flag is applied only after the window
        bat_low_in = 1'b1; cyc(12);
        check("R4 before window", adv_pwr, 120);
        cyc(18);
        check("R4 after window", adv_pwr, 90);

        // R5: clearing restores full power quickly
        bat_low_in = 1'b0; cyc(5);
        check("R5 battery clear", adv_pwr, 120);
        therm_warn_in = 1'b1; cyc(10);
        check("R2 thermal only", adv_pwr, 90);
        therm_warn_in = 1'b0; cyc(5);
        check("R5 thermal clear", adv_pwr, 120);

        // R6: short select glitch is ignored
        cyc(5); pulses = 0;
        sel_pins = 2'b00; cyc(2); sel_pins = 2'b11; cyc(20);
        check("R6 glitch value", adv_pwr, 120);
        check("R6 glitch pulses", pulses, 0);

        // R6: a stable new code is adopted after the debounce
        sel_pins = 2'b10; cyc(3);
        check("R6 before debounce", adv_pwr, 120);
        cyc(12);
        check("R6 after debounce", adv_pwr, 90);
        check("R7 one pulse", pulses, 1);

        done = 1;
        finish_run();
    end
endmodule